// File: doc/BRIEF.md
# Mailbox Transmit Request Controller

This block keeps one pending-transmit flag for each mailbox of a 32-mailbox CAN-style message controller. Software raises flags through a set-request write port and drops them through a separate cancel write port. A direction input tells the block which mailboxes may transmit. The topmost mailbox only receives, so its flag can never be raised.

From the pending flags the block picks the next mailbox to offer to a transmit engine. Two ordering rules are available. An engine takes the offer with a start pulse and later returns a done pulse with a pass/fail result. A pass drops the flag. A fail leaves the flag up, so the mailbox is offered again. While an attempt is in flight the choice is frozen. A cancel aimed at that mailbox is held back until the attempt ends.

A write-protect output flags any attempt to change the contents of a mailbox whose request is still pending.

Top module: `txreq_ctrl`

## Requirements
- R1: Flag bit 31 (the receive-only mailbox) always reads 0. Writing 1 to it on either write port has no effect.
- R2: When `set_we` is high, a 1 in `set_data[i]` raises flag i only if `dir_tx[i]` is 1 (1 = transmit, 0 = receive).
- R3: A 0 in `set_data` never lowers a flag. Only a pass result or a cancel lowers one.
- R4: When the engine reports done with `eng_ok`=1, the in-flight mailbox's flag is 0 on the next cycle.
- R5: When `rst_we` is high, a 1 in `rst_data[i]` lowers flag i on the next cycle if mailbox i is not in flight.
- R6: When the engine reports done with `eng_ok`=0 and no cancel is pending for that mailbox, its flag stays 1. It is offered again on the next cycle.
- R7: With `prio_mode`=0, the offered mailbox is the highest-numbered pending one.
- R8: With `prio_mode`=1, the offered mailbox is the pending one with the lowest 4-bit value in `prio_flat[4*i+3:4*i]`. A tie goes to the higher mailbox number.
- R9: `eng_start` while `sel_valid`=1 begins an attempt on `sel_idx`. While busy, `sel_valid` is 0 and `sel_idx` holds the in-flight mailbox, whatever the flags or the mode do.
- R10: A cancel of the in-flight mailbox leaves its flag at 1 until the attempt ends. On done it is cleared, whatever the result.
- R11: If a clear (pass or cancel) and a set hit the same bit in the same cycle, the bit ends at 0.
- R12: `wr_violation` is `mb_wr_en` AND the flag of mailbox `mb_wr_idx`, combinationally.
- R13: After reset all flags are 0, `sel_valid` is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_we | input | 1 | Set-request write strobe |
| set_data | input | 32 | Set-request bit mask |
| rst_we | input | 1 | Cancel write strobe |
| rst_data | input | 32 | Cancel bit mask |
| dir_tx | input | 32 | Per-mailbox direction, 1 = transmit |
| prio_mode | input | 1 | 0 = by index, 1 = by programmed value |
| prio_flat | input | 128 | 4-bit priority value per mailbox |
| eng_start | input | 1 | Engine takes the offered mailbox |
| eng_done | input | 1 | Engine attempt finished |
| eng_ok | input | 1 | Attempt result, 1 = sent |
| mb_wr_en | input | 1 | Mailbox content write attempt |
| mb_wr_idx | input | 5 | Mailbox targeted by that write |
| pending | output | 32 | Pending request flags |
| sel_idx | output | 5 | Offered (or in-flight) mailbox |
| sel_valid | output | 1 | An offer is available |
| busy | output | 1 | An attempt is in flight |
| wr_violation | output | 1 | Write to a mailbox with a pending request |

## Verification
The hardest case to reach from the ports is a cancel that lands on the mailbox already in flight. That cancel must be held back and then applied when a failing result comes back. The bench gets there by letting the engine take a mailbox, sending the cancel while `busy` is high, and then returning a failed result. It checks `pending` both before and after that result. A failed attempt followed by a re-offer, and a mode change during an attempt, are driven in the same way: the bench holds the engine mid-attempt while it changes the other inputs.

// File: rtl/txreq_pkg.sv
package txreq_pkg;
  typedef enum logic {
    ORDER_BY_INDEX = 1'b0,
    ORDER_BY_VALUE = 1'b1
  } order_e;
endpackage

// File: rtl/txreq_picker.sv
module txreq_picker #(
  parameter int NUM_MB = 32,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_MB-1:0]        pend,
  input  txreq_pkg::order_e        mode,
  input  logic [NUM_MB*PRIO_W-1:0] prio_flat,
  output logic [IDX_W-1:0]         pick_idx,
  output logic                     pick_any
);
  // Highest-numbered set bit wins.
  function automatic logic [IDX_W-1:0] pick_by_index(input logic [NUM_MB-1:0] p);
    logic [IDX_W-1:0] best;
    best = '0;
    for (int i = 0; i < NUM_MB; i++)
      if (p[i]) best = IDX_W'(i);
    return best;
  endfunction

  // Lowest value wins; scanning upward with <= lets the higher index take a tie.
  function automatic logic [IDX_W-1:0] pick_by_value(input logic [NUM_MB-1:0] p,
                                                     input logic [NUM_MB*PRIO_W-1:0] pv);
    logic [IDX_W-1:0]  best;
    logic [PRIO_W-1:0] best_v;
    logic              found;
    best = '0;
    best_v = '1;
    found = 1'b0;
    for (int i = 0; i < NUM_MB; i++)
      if (p[i] && (!found || pv[i*PRIO_W +: PRIO_W] <= best_v)) begin
        best   = IDX_W'(i);
        best_v = pv[i*PRIO_W +: PRIO_W];
        found  = 1'b1;
      end
    return best;
  endfunction

  always_comb begin
    pick_any = |pend;
    pick_idx = (mode == txreq_pkg::ORDER_BY_VALUE) ? pick_by_value(pend, prio_flat)
                                                   : pick_by_index(pend);
  end

  // R7
  pick_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> pend[pick_idx]);
endmodule

// File: rtl/txreq_track.sv
module txreq_track #(
  parameter int NUM_MB = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer_valid,
  input  logic [IDX_W-1:0]  offer_idx,
  input  logic              eng_start,
  input  logic              eng_done,
  input  logic              eng_ok,
  input  logic              rst_we,
  input  logic [NUM_MB-1:0] rst_data,
  input  logic [NUM_MB-1:0] pend,
  output logic              busy,
  output logic [IDX_W-1:0]  fly_idx,
  output logic              clear_fly
);
  logic defer_q;
  logic cancel_hit;
  logic attempt_end;
  logic attempt_begin;

  assign cancel_hit    = busy && rst_we && rst_data[fly_idx];
  assign attempt_end   = busy && eng_done;
  assign attempt_begin = !busy && offer_valid && eng_start;
  assign clear_fly     = attempt_end && (eng_ok || defer_q || cancel_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      fly_idx <= '0;
      defer_q <= 1'b0;
    end else begin
      if (attempt_begin) begin
        busy    <= 1'b1;
        fly_idx <= offer_idx;
      end else if (attempt_end) begin
        busy    <= 1'b0;
      end
      if (attempt_end || !busy) defer_q <= 1'b0;
      else if (cancel_hit)      defer_q <= 1'b1;
    end
  end

  // R6
  fail_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_end && !eng_ok && !defer_q && !cancel_hit |=> pend[fly_idx]);
  // R10
  deferred_cancel_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_hit && !eng_done |=> pend[fly_idx]);
endmodule

// File: rtl/txreq_flags.sv
module txreq_flags #(
  parameter int NUM_MB = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic [NUM_MB-1:0] set_data,
  input  logic              rst_we,
  input  logic [NUM_MB-1:0] rst_data,
  input  logic [NUM_MB-1:0] dir_tx,
  input  logic              busy,
  input  logic [IDX_W-1:0]  fly_idx,
  input  logic              clear_fly,
  output logic [NUM_MB-1:0] pend_q
);
  localparam logic [NUM_MB-1:0] TX_CAPABLE = {1'b0, {(NUM_MB-1){1'b1}}};

  logic [NUM_MB-1:0] set_mask;
  logic [NUM_MB-1:0] cancel_mask;
  logic [NUM_MB-1:0] done_mask;
  logic [NUM_MB-1:0] pend_d;

  assign set_mask  = set_we ? (set_data & dir_tx & TX_CAPABLE) : '0;
  assign done_mask = clear_fly ? (NUM_MB'(1) << fly_idx) : '0;

  always_comb begin
    cancel_mask = rst_we ? rst_data : '0;
    if (busy) cancel_mask[fly_idx] = 1'b0;  // in-flight cancel is deferred
  end

  assign pend_d = (pend_q | set_mask) & ~(cancel_mask | done_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R1
  top_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[NUM_MB-1]);
  // R2
  rx_never_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(dir_tx)) == '0);
  // R3
  no_cpu_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_fly && !rst_we |=> (($past(pend_q) & ~pend_q) == '0));
  // R11
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_we && !busy |=> ((pend_q & $past(rst_data)) == '0));
endmodule

// File: rtl/txreq_ctrl.sv
module txreq_ctrl #(
  parameter int NUM_MB = 32,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_we,
  input  logic [NUM_MB-1:0]        set_data,
  input  logic                     rst_we,
  input  logic [NUM_MB-1:0]        rst_data,
  input  logic [NUM_MB-1:0]        dir_tx,
  input  logic                     prio_mode,
  input  logic [NUM_MB*PRIO_W-1:0] prio_flat,
  input  logic                     eng_start,
  input  logic                     eng_done,
  input  logic                     eng_ok,
  input  logic                     mb_wr_en,
  input  logic [IDX_W-1:0]         mb_wr_idx,
  output logic [NUM_MB-1:0]        pending,
  output logic [IDX_W-1:0]         sel_idx,
  output logic                     sel_valid,
  output logic                     busy,
  output logic                     wr_violation
);
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;
  logic [IDX_W-1:0]  fly_idx;
  logic              clear_fly;
  txreq_pkg::order_e mode;

  assign mode = txreq_pkg::order_e'(prio_mode);

  txreq_flags #(.NUM_MB(NUM_MB)) flags_i (
    .clk(clk), .rst_n(rst_n),
    .set_we(set_we), .set_data(set_data),
    .rst_we(rst_we), .rst_data(rst_data),
    .dir_tx(dir_tx), .busy(busy), .fly_idx(fly_idx),
    .clear_fly(clear_fly), .pend_q(pending)
  );

  txreq_picker #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W)) picker_i (
    .clk(clk), .rst_n(rst_n),
    .pend(pending), .mode(mode), .prio_flat(prio_flat),
    .pick_idx(pick_idx), .pick_any(pick_any)
  );

  txreq_track #(.NUM_MB(NUM_MB)) track_i (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(sel_valid), .offer_idx(sel_idx),
    .eng_start(eng_start), .eng_done(eng_done), .eng_ok(eng_ok),
    .rst_we(rst_we), .rst_data(rst_data), .pend(pending),
    .busy(busy), .fly_idx(fly_idx), .clear_fly(clear_fly)
  );

  assign sel_valid    = !busy && pick_any;
  assign sel_idx      = busy ? fly_idx : pick_idx;
  assign wr_violation = mb_wr_en && pending[mb_wr_idx];

  // R9
  frozen_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy |-> $stable(sel_idx));
  // R9
  no_offer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sel_valid);
  // R4
  pass_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && eng_done && eng_ok |=> !pending[$past(sel_idx)]);
  // R12
  write_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wr_en && pending[mb_wr_idx] |-> wr_violation);
endmodule

// File: tb/txreq_ctrl_tb_top.sv
module txreq_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         set_we = 1'b0, rst_we = 1'b0;
  logic [31:0]  set_data = '0, rst_data = '0, dir_tx = '0;
  logic         prio_mode = 1'b0;
  logic [127:0] prio_flat = '1;
  logic         eng_start = 1'b0, eng_done = 1'b0, eng_ok = 1'b0;
  logic         mb_wr_en = 1'b0;
  logic [4:0]   mb_wr_idx = '0;
  logic [31:0]  pending;
  logic [4:0]   sel_idx;
  logic         sel_valid, busy, wr_violation;
  int           n_chk = 0, n_fail = 0;
  bit           done_flag = 1'b0;

  always #2 clk = ~clk;

  txreq_ctrl dut_i (.*);

  typedef struct packed {
    logic [31:0] sdat;
    logic [31:0] dir;
    logic [31:0] rdat;
    logic [31:0] exp_pend;
    logic [4:0]  exp_sel;
    logic        exp_valid;
  } vec_t;

  // set/cancel sequence, mode 0, engine idle
  localparam vec_t TBL [6] = '{
    '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0,         32'h0000_FFFF, 5'd15, 1'b1}, // R2
    '{32'h0,         32'hFFFF_FFFF, 32'h0000_000F, 32'h0000_FFF0, 5'd15, 1'b1}, // R3 R5
    '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0,         32'h0000_FFF0, 5'd15, 1'b1}, // R1
    '{32'h00F0_0000, 32'h0,         32'h0,         32'h0000_FFF0, 5'd15, 1'b1}, // R2
    '{32'h0000_00FF, 32'hFFFF_FFFF, 32'h0000_00F0, 32'h0000_FF0F, 5'd15, 1'b1}, // R11
    '{32'h0,         32'h0,         32'hFFFF_FFFF, 32'h0,         5'd0,  1'b0}  // R5
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(); step();
    // R13 reset state
    chk("R13 pending", pending, 32'h0);
    chk("R13 sel_valid", {31'h0, sel_valid}, 32'h0);
    chk("R13 busy", {31'h0, busy}, 32'h0);
    rst_n = 1'b1;
    step();

    for (int k = 0; k < 6; k++) begin
      set_we = 1'b1; set_data = TBL[k].sdat;
      rst_we = 1'b1; rst_data = TBL[k].rdat;
      dir_tx = TBL[k].dir;
      step();
      set_we = 1'b0; rst_we = 1'b0;
      #1;
      chk("R1/R2/R3/R5/R11 pending", pending, TBL[k].exp_pend);
      chk("R7 sel_valid", {31'h0, sel_valid}, {31'h0, TBL[k].exp_valid});
      if (TBL[k].exp_valid) chk("R7 sel_idx", {27'h0, sel_idx}, {27'h0, TBL[k].exp_sel});
    end

    // raise 3, 5, 9
    dir_tx = 32'hFFFF_FFFF;
    set_we = 1'b1; set_data = 32'h0000_0228;
    step();
    set_we = 1'b0;
    prio_flat[3*4 +: 4] = 4'd2;
    prio_flat[5*4 +: 4] = 4'd1;
    prio_flat[9*4 +: 4] = 4'd1;
    prio_mode = 1'b1;
    #1 chk("R8 tie to higher index", {27'h0, sel_idx}, 32'd9);
    prio_flat[3*4 +: 4] = 4'd0;
    #1 chk("R8 lowest value", {27'h0, sel_idx}, 32'd3);
    prio_mode = 1'b0;
    #1 chk("R7 highest index", {27'h0, sel_idx}, 32'd9);

    // attempt on 9, fails
    eng_start = 1'b1;
    step();
    eng_start = 1'b0;
    #1;
    chk("R9 busy", {31'h0, busy}, 32'h1);
    chk("R9 no offer while busy", {31'h0, sel_valid}, 32'h0);
    prio_mode = 1'b1;
    #1 chk("R9 frozen sel_idx", {27'h0, sel_idx}, 32'd9);
    prio_mode = 1'b0;
    eng_done = 1'b1; eng_ok = 1'b0;
    step();
    eng_done = 1'b0;
    #1;
    chk("R6 flag kept after fail", pending, 32'h0000_0228);
    chk("R6 re-offered", {26'h0, sel_valid, sel_idx}, {26'h0, 1'b1, 5'd9});

    // retry on 9, passes
    eng_start = 1'b1;
    step();
    eng_start = 1'b0;
    eng_done = 1'b1; eng_ok = 1'b1;
    step();
    eng_done = 1'b0; eng_ok = 1'b0;
    #1;
    chk("R4 pass clears", pending, 32'h0000_0028);
    chk("R4 next offer", {27'h0, sel_idx}, 32'd5);

    // attempt on 5, cancel while in flight, then fail
    eng_start = 1'b1;
    step();
    eng_start = 1'b0;
    rst_we = 1'b1; rst_data = 32'h0000_0020;
    step();
    rst_we = 1'b0;
    #1 chk("R10 cancel deferred", pending, 32'h0000_0028);
    eng_done = 1'b1; eng_ok = 1'b0;
    step();
    eng_done = 1'b0;
    #1;
    chk("R10 cancel applied at end", pending, 32'h0000_0008);
    chk("R10 next offer", {27'h0, sel_idx}, 32'd3);

    // write guard
    mb_wr_en = 1'b1; mb_wr_idx = 5'd3;
    #1 chk("R12 pending mailbox", {31'h0, wr_violation}, 32'h1);
    mb_wr_idx = 5'd5;
    #1 chk("R12 idle mailbox", {31'h0, wr_violation}, 32'h0);
    mb_wr_en = 1'b0;
    #1 chk("R12 no write", {31'h0, wr_violation}, 32'h0);

    step();
    finish_run();
  end
endmodule